// File: doc/BRIEF.md
# Segmented Double-Buffered DAC Code Register

This block is the synchronous digital front end of a 12-bit converter. A 4-bit host bus feeds three 4-bit input segments. Each segment is written while the active-low chip enable and that segment's own enable are both asserted. The three segments are the high nibble (code bits 11:8), the middle nibble (7:4) and the low nibble (3:0). When several segment enables are active together, they all take the same bus nibble in that access. This lets a narrow host fill the code one nibble per access, or replicate a nibble across segments.

A second 12-bit register stands between the segments and the converter. While the transfer strobe is high, it follows the segments. While the strobe is low, it keeps its value, so the segments can be rewritten without disturbing the output.

Only this holding register drives the code outputs:
- a straight binary view for unipolar use;
- its bitwise complement;
- an offset-binary view, expressed as a two's-complement value in which code 0x800 reads as zero.

A settle flag drops on every transfer and returns after a programmable number of cycles. A pulse flags any chip-enable/segment-enable overlap that is shorter than a minimum window.

Top module: `dac_dbuf_front`

## Requirements
- R1: A synchronous active-high reset clears all three segments, the holding register and the error pulse. Afterwards `code_out` is 0x000, `code_cmpl` is 0xFFF, `code_bip` is 0x800 and `code_valid` is 1.
- R2: Segment mapping: `seg_en_hi` writes code bits 11:8, `seg_en_mid` writes bits 7:4 and `seg_en_lo` writes bits 3:0, each from `bus_data[3:0]`.
- R3: A segment changes only in cycles where `chip_en_n` is 0 and its enable is 1. With `chip_en_n` high, no segment changes, whatever the segment enables and bus carry.
- R4: Several segment enables active together all load the same bus nibble in the same cycle.
- R5: While `xfer` is 0, `code_out` holds its value, including while segments are being rewritten.
- R6: In each clock cycle where `xfer` is 1, the holding register takes the segment contents as they stand after that cycle's writes. A write and a transfer in the same cycle therefore reach `code_out` after the same edge.
- R7: `code_cmpl` is the bitwise inverse of `code_out`. `code_bip` is `code_out` with bit 11 inverted, i.e. `code_out` minus 0x800 in two's complement.
- R8: A contiguous run in which `chip_en_n` is low and a given segment enable is high raises `proto_err` for exactly one cycle after the run ends, if the run lasted fewer than `MIN_WIN_CYC` cycles. A run of `MIN_WIN_CYC` or more cycles raises nothing.
- R9: A clock edge that samples `xfer` high clears `code_valid`. The flag returns to 1 after `OUT_DLY` further edges with `xfer` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 4 | Host data nibble |
| chip_en_n | input | 1 | Chip enable, active low |
| seg_en_hi | input | 1 | Enable for code bits 11:8 |
| seg_en_mid | input | 1 | Enable for code bits 7:4 |
| seg_en_lo | input | 1 | Enable for code bits 3:0 |
| xfer | input | 1 | Transfer strobe, level sensitive, high = follow |
| code_out | output | 12 | Held code, straight binary |
| code_cmpl | output | 12 | Held code, complemented |
| code_bip | output | 12 | Held code, offset binary as two's complement |
| code_valid | output | 1 | High once the output delay after a transfer has elapsed |
| proto_err | output | 1 | One-cycle pulse on a too-short write window |

## Verification
The assertions assume that every control input is already synchronous to `clk`, so an enable level seen at one edge is the level the logic used. The stimulus therefore changes only on falling edges. Write windows are held at exactly the minimum length, except for the deliberately short windows used to provoke the error pulse. Transfers are issued as separate strobe pulses between writes, with one deliberate overlap that exercises same-cycle write and transfer.

// File: rtl/dacf_pkg.sv
package dacf_pkg;
    localparam int SEG_W  = 4;
    localparam int N_SEG  = 3;
    localparam int CODE_W = SEG_W * N_SEG;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t straight;
        code_t cmpl;
        code_t offs;
    } code_views_t;

    function automatic code_views_t make_views(code_t c);
        code_views_t v;
        v.straight = c;
        v.cmpl     = ~c;
        v.offs     = {~c[CODE_W-1], c[CODE_W-2:0]};
        return v;
    endfunction
endpackage

// File: rtl/dacf_seg_reg.sv
module dacf_seg_reg #(
    parameter int SEG_W       = 4,
    parameter int MIN_WIN_CYC = 63
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic [SEG_W-1:0] din,
    output logic [SEG_W-1:0] q_next,
    output logic [SEG_W-1:0] q,
    output logic             short_err
);
    localparam int CW = $clog2(MIN_WIN_CYC + 1);
    localparam logic [CW-1:0] WIN_MAX = CW'(MIN_WIN_CYC);

    logic [SEG_W-1:0] q_r;
    logic [CW-1:0]    cnt_q;
    logic             err_q;

    // level-sensitive capture modelled as per-cycle sampling
    always_comb q_next = sel ? din : q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r   <= '0;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            q_r <= q_next;
            if (sel)
                cnt_q <= (cnt_q == WIN_MAX) ? cnt_q : cnt_q + 1'b1;
            else
                cnt_q <= '0;
            err_q <= !sel && (cnt_q != '0) && (cnt_q < WIN_MAX);
        end
    end

    assign q         = q_r;
    assign short_err = err_q;

    AST_SEG_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(q_r)); // R3

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        err_q |=> !err_q); // R8
endmodule

// File: rtl/dacf_hold_reg.sv
module dacf_hold_reg #(
    parameter int CODE_W  = 12,
    parameter int OUT_DLY = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] hold,
    output logic              valid
);
    localparam int DW = (OUT_DLY > 0) ? $clog2(OUT_DLY + 1) : 1;
    localparam logic [DW-1:0] DLY_LOAD = DW'(OUT_DLY);

    logic [CODE_W-1:0] hold_q;
    logic [DW-1:0]     dly_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            dly_q  <= '0;
        end else begin
            if (xfer) begin
                hold_q <= din;
                dly_q  <= DLY_LOAD;
            end else if (dly_q != '0) begin
                dly_q <= dly_q - 1'b1;
            end
        end
    end

    assign hold  = hold_q;
    assign valid = (dly_q == '0);

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(hold_q)); // R5

    AST_HOLD_TRACK: assert property (@(posedge clk) disable iff (rst)
        xfer |=> hold_q == $past(din)); // R6

    generate
        if (OUT_DLY > 0) begin : g_dly_chk
            AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
                xfer |=> !valid); // R9
        end
    endgenerate
endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front
    import dacf_pkg::*;
#(
    parameter int MIN_WIN_CYC = 63, // 250 ns at a 4 ns clock, rounded up
    parameter int OUT_DLY     = 50  // 200 ns at a 4 ns clock
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEG_W-1:0]  bus_data,
    input  logic              chip_en_n,
    input  logic              seg_en_hi,
    input  logic              seg_en_mid,
    input  logic              seg_en_lo,
    input  logic              xfer,
    output logic [CODE_W-1:0] code_out,
    output logic [CODE_W-1:0] code_cmpl,
    output logic [CODE_W-1:0] code_bip,
    output logic              code_valid,
    output logic              proto_err
);
    logic [N_SEG-1:0] seg_en;
    logic [N_SEG-1:0] seg_sel;
    logic [N_SEG-1:0] seg_err;
    code_t            seg_next;
    code_t            seg_cur;
    code_t            hold;
    code_views_t      views;

    // index 0 = low nibble, N_SEG-1 = high nibble
    assign seg_en = {seg_en_hi, seg_en_mid, seg_en_lo};

    generate
        for (genvar i = 0; i < N_SEG; i++) begin : g_seg
            assign seg_sel[i] = !chip_en_n && seg_en[i];
            dacf_seg_reg #(
                .SEG_W       (SEG_W),
                .MIN_WIN_CYC (MIN_WIN_CYC)
            ) u_seg (
                .clk       (clk),
                .rst       (rst),
                .sel       (seg_sel[i]),
                .din       (bus_data),
                .q_next    (seg_next[i*SEG_W +: SEG_W]),
                .q         (seg_cur[i*SEG_W +: SEG_W]),
                .short_err (seg_err[i])
            );
        end
    endgenerate

    dacf_hold_reg #(
        .CODE_W  (CODE_W),
        .OUT_DLY (OUT_DLY)
    ) u_hold (
        .clk   (clk),
        .rst   (rst),
        .xfer  (xfer),
        .din   (seg_next),
        .hold  (hold),
        .valid (code_valid)
    );

    always_comb views = make_views(hold);

    assign code_out  = views.straight;
    assign code_cmpl = views.cmpl;
    assign code_bip  = views.offs;
    assign proto_err = |seg_err;

    AST_CE_GATES_ALL: assert property (@(posedge clk) disable iff (rst)
        chip_en_n |=> seg_cur == $past(seg_cur)); // R3

    AST_SEG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!chip_en_n && seg_en_hi) |=> seg_cur[CODE_W-1 -: SEG_W] == $past(bus_data)); // R2
endmodule

// File: tb/sim_dac_dbuf_front.sv
module sim_dac_dbuf_front;
    localparam int MINW = 4;
    localparam int DLY  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_data = '0;
    logic        chip_en_n = 1'b1;
    logic        seg_en_hi = 1'b0, seg_en_mid = 1'b0, seg_en_lo = 1'b0;
    logic        xfer = 1'b0;
    logic [11:0] code_out, code_cmpl, code_bip;
    logic        code_valid, proto_err;

    int n_chk = 0, n_fail = 0, n_err = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    dac_dbuf_front #(.MIN_WIN_CYC(MINW), .OUT_DLY(DLY)) u0 (
        .clk(clk), .rst(rst), .bus_data(bus_data), .chip_en_n(chip_en_n),
        .seg_en_hi(seg_en_hi), .seg_en_mid(seg_en_mid), .seg_en_lo(seg_en_lo),
        .xfer(xfer), .code_out(code_out), .code_cmpl(code_cmpl), .code_bip(code_bip),
        .code_valid(code_valid), .proto_err(proto_err)
    );

    always @(posedge clk) if (proto_err) n_err <= n_err + 1;

    typedef struct packed {
        logic        ce_n;
        logic [2:0]  en;   // {hi, mid, lo}
        logic [3:0]  nib;
        logic        ld;
        logic [11:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'b100, 4'hA, 1'b0, 12'h000},
        '{1'b0, 3'b010, 4'h5, 1'b0, 12'h000},
        '{1'b0, 3'b001, 4'hC, 1'b1, 12'hA5C},
        '{1'b1, 3'b111, 4'hF, 1'b0, 12'hA5C},
        '{1'b1, 3'b000, 4'h0, 1'b1, 12'hA5C},
        '{1'b0, 3'b011, 4'h3, 1'b0, 12'hA5C},
        '{1'b0, 3'b000, 4'h9, 1'b1, 12'hA33},
        '{1'b0, 3'b111, 4'h8, 1'b1, 12'h888},
        '{1'b0, 3'b100, 4'h0, 1'b0, 12'h888},
        '{1'b0, 3'b101, 4'h7, 1'b1, 12'h787}
    };

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic seg_write(input logic cen, input logic [2:0] en,
                             input logic [3:0] nib, input logic ld, input int len);
        @(negedge clk);
        chip_en_n = cen;
        {seg_en_hi, seg_en_mid, seg_en_lo} = en;
        bus_data = nib;
        xfer = ld;
        repeat (len) @(negedge clk);
        chip_en_n = 1'b1;
        {seg_en_hi, seg_en_mid, seg_en_lo} = 3'b000;
        xfer = 1'b0;
    endtask

    task automatic pulse_xfer();
        @(negedge clk);
        xfer = 1'b1;
        @(negedge clk);
        xfer = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [11:0] prev;
        int e0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 code_out", code_out, 12'h000);
        chk("R1 code_cmpl", code_cmpl, 12'hFFF);
        chk("R1 code_bip", code_bip, 12'h800);
        chk("R1 code_valid", {11'b0, code_valid}, 12'h001);
        chk("R1 proto_err", {11'b0, proto_err}, 12'h000);

        // table: R2 R3 R4 R5 R6 R7
        prev = 12'h000;
        for (int i = 0; i < NV; i++) begin
            seg_write(VECS[i].ce_n, VECS[i].en, VECS[i].nib, 1'b0, MINW);
            @(negedge clk);
            chk("R5 output frozen during writes", code_out, prev);
            if (VECS[i].ld) pulse_xfer();
            chk("R2 R3 R4 R6 code_out", code_out, VECS[i].exp);
            chk("R7 code_cmpl", code_cmpl, ~VECS[i].exp);
            chk("R7 code_bip", code_bip, VECS[i].exp ^ 12'h800);
            prev = VECS[i].exp;
        end
        repeat (2) @(negedge clk);
        chk("R8 no error on full windows", n_err[11:0], 12'h000);

        // R6 write and transfer in the same cycles
        seg_write(1'b0, 3'b001, 4'h2, 1'b1, MINW);
        chk("R6 flow-through", code_out, 12'h782);
        repeat (8) @(negedge clk);

        // R9 settle flag timing
        chk("R9 valid idle", {11'b0, code_valid}, 12'h001);
        @(negedge clk);
        xfer = 1'b1;
        @(negedge clk);
        xfer = 1'b0;
        chk("R9 valid low after xfer", {11'b0, code_valid}, 12'h000);
        repeat (2) @(negedge clk);
        chk("R9 valid low before delay", {11'b0, code_valid}, 12'h000);
        @(negedge clk);
        chk("R9 valid back after delay", {11'b0, code_valid}, 12'h001);

        // R8 short windows
        e0 = n_err;
        seg_write(1'b0, 3'b010, 4'h1, 1'b0, 2);
        repeat (2) @(negedge clk);
        chk("R8 two-cycle window", 12'(n_err - e0), 12'h001);
        e0 = n_err;
        seg_write(1'b0, 3'b010, 4'h1, 1'b0, MINW - 1);
        repeat (2) @(negedge clk);
        chk("R8 window one short", 12'(n_err - e0), 12'h001);
        e0 = n_err;
        seg_write(1'b0, 3'b010, 4'h1, 1'b0, MINW);
        repeat (2) @(negedge clk);
        chk("R8 exact window", 12'(n_err - e0), 12'h000);
        e0 = n_err;
        seg_write(1'b1, 3'b111, 4'h6, 1'b0, 2);
        repeat (2) @(negedge clk);
        chk("R8 R3 no window without chip enable", 12'(n_err - e0), 12'h000);
        pulse_xfer();
        chk("R3 chip enable high ignored", code_out, 12'h712);

        // R1 reset mid-run clears segments too
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 code_out after reset", code_out, 12'h000);
        chk("R1 code_bip after reset", code_bip, 12'h800);
        pulse_xfer();
        chk("R1 segments cleared", code_out, 12'h000);

        finish_run();
    end
endmodule